// File: doc/BRIEF.md
# Two-Level Lookahead Adder (16-bit)

This block adds two 16-bit operands and a carry-in in purely combinational logic. The operands are split into four 4-bit slices. Each slice derives a generate and a propagate term for every bit. From those terms it forms all of its internal carries as flat sum-of-products expressions, so no carry ripples from bit to bit inside a slice. Each slice also reports a slice-level propagate and generate.

A second lookahead stage takes the four slice propagate/generate pairs and the external carry-in. From them it computes the carry into slices 1, 2 and 3 and the final carry-out, again as flat sum-of-products terms. No carry passes from one slice to the next through a chain. The slice propagate/generate pairs are brought out as ports, so a wider adder can stack a third lookahead level over several copies of this block.

Top module: `cla16_adder`

## Requirements
- R1: `sum` equals (`op_a` + `op_b` + `carry_in`) modulo 2^16, in the same cycle the inputs are applied. There is no register between the inputs and the outputs.
- R2: `carry_out` equals bit 16 of the unsigned sum `op_a` + `op_b` + `carry_in`.
- R3: `grp_prop[k]` is 1 exactly when every bit position in slice k (bits 4k+3 down to 4k) has at least one operand bit set. Slice 0 holds bits 3:0, and its flag sits at bit 0 of the port.
- R4: `grp_gen[k]` is 1 exactly when adding the two 4-bit slices k, with no carry-in, overflows past 4 bits. The bit ordering is the same as in R3.
- R5: The carry into slice k+1 equals `grp_gen[k]` OR (`grp_prop[k]` AND the carry into slice k). The carry into slice 0 is `carry_in`. A carry-in on a fully propagating operand pair, such as all-ones plus zero, reaches `carry_out` and clears every sum bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum | output | 16 | Sum modulo 2^16 |
| carry_out | output | 1 | Carry out of bit 15 |
| grp_prop | output | 4 | Slice propagate flags, bit k for slice k |
| grp_gen | output | 4 | Slice generate flags, bit k for slice k |

## Verification
The assertions are immediate checks on settled combinational values. They assume that every input carries a defined 0 or 1, with no X or Z, whenever the logic is evaluated. The bench drives every operand bit and `carry_in` from the first cycle, including the reset interval. It changes the inputs only just after a rising edge and samples at the falling edge. Each set of values therefore stays stable for half a period before it is compared.

// File: rtl/cla16_pkg.sv
package cla16_pkg;

  localparam int unsigned LA_MAX = 16;

  // Flat sum-of-products carry into position k:
  // OR over j<k of (g[j] AND p[j+1..k-1]) OR (cin AND p[0..k-1]).
  function automatic logic la_carry(
    input logic [LA_MAX-1:0] g,
    input logic [LA_MAX-1:0] p,
    input logic              cin,
    input int unsigned       k
  );
    logic acc;
    logic term;
    acc = 1'b0;
    for (int unsigned j = 0; j < LA_MAX; j++) begin
      if (j < k) begin
        term = g[j];
        for (int unsigned m = 0; m < LA_MAX; m++) begin
          if (m > j && m < k) term = term & p[m];
        end
        acc = acc | term;
      end
    end
    term = cin;
    for (int unsigned m = 0; m < LA_MAX; m++) begin
      if (m < k) term = term & p[m];
    end
    return acc | term;
  endfunction

  // AND of the first n propagate terms.
  function automatic logic la_all_prop(
    input logic [LA_MAX-1:0] p,
    input int unsigned       n
  );
    logic acc;
    acc = 1'b1;
    for (int unsigned m = 0; m < LA_MAX; m++) begin
      if (m < n) acc = acc & p[m];
    end
    return acc;
  endfunction

endpackage

// File: rtl/cla_slice.sv
module cla_slice #(
  parameter int unsigned SLICE_W = 4
) (
  input  logic [SLICE_W-1:0] a,
  input  logic [SLICE_W-1:0] b,
  input  logic               cin,
  output logic [SLICE_W-1:0] s,
  output logic               slice_p,
  output logic               slice_g
);
  import cla16_pkg::*;

  logic [SLICE_W-1:0] bit_g;
  logic [SLICE_W-1:0] bit_p;
  logic [SLICE_W-1:0] bit_c;
  logic [LA_MAX-1:0]  g_ext;
  logic [LA_MAX-1:0]  p_ext;

  assign bit_g = a & b;
  assign bit_p = a | b;

  always_comb begin
    g_ext = '0;
    p_ext = '0;
    g_ext[SLICE_W-1:0] = bit_g;
    p_ext[SLICE_W-1:0] = bit_p;
  end

  for (genvar i = 0; i < SLICE_W; i++) begin : g_bit
    assign bit_c[i] = la_carry(g_ext, p_ext, cin, i);
  end

  assign s       = a ^ b ^ bit_c;
  assign slice_p = la_all_prop(p_ext, SLICE_W);
  assign slice_g = la_carry(g_ext, p_ext, 1'b0, SLICE_W);
endmodule

// File: rtl/cla_lookahead.sv
module cla_lookahead #(
  parameter int unsigned NUM_SLICES = 4
) (
  input  logic [NUM_SLICES-1:0] sp,
  input  logic [NUM_SLICES-1:0] sg,
  input  logic                  cin,
  output logic [NUM_SLICES:0]   carries
);
  import cla16_pkg::*;

  logic [LA_MAX-1:0] g_ext;
  logic [LA_MAX-1:0] p_ext;

  always_comb begin
    g_ext = '0;
    p_ext = '0;
    g_ext[NUM_SLICES-1:0] = sg;
    p_ext[NUM_SLICES-1:0] = sp;
  end

  for (genvar k = 0; k <= NUM_SLICES; k++) begin : g_carry
    assign carries[k] = la_carry(g_ext, p_ext, cin, k);
  end
endmodule

// File: rtl/cla16_adder.sv
module cla16_adder #(
  parameter int unsigned SLICE_W    = 4,
  parameter int unsigned NUM_SLICES = 4,
  localparam int unsigned WIDTH     = SLICE_W * NUM_SLICES
) (
  input  logic [WIDTH-1:0]      op_a,
  input  logic [WIDTH-1:0]      op_b,
  input  logic                  carry_in,
  output logic [WIDTH-1:0]      sum,
  output logic                  carry_out,
  output logic [NUM_SLICES-1:0] grp_prop,
  output logic [NUM_SLICES-1:0] grp_gen
);
  import cla16_pkg::*;

  // Carry into each slice, plus the final carry-out, from the second level.
  logic [NUM_SLICES:0] grp_cin;

  cla_lookahead #(.NUM_SLICES(NUM_SLICES)) u_lookahead (
    .sp      (grp_prop),
    .sg      (grp_gen),
    .cin     (carry_in),
    .carries (grp_cin)
  );

  for (genvar k = 0; k < NUM_SLICES; k++) begin : g_slice
    cla_slice #(.SLICE_W(SLICE_W)) u_slice (
      .a       (op_a[k*SLICE_W +: SLICE_W]),
      .b       (op_b[k*SLICE_W +: SLICE_W]),
      .cin     (grp_cin[k]),
      .s       (sum[k*SLICE_W +: SLICE_W]),
      .slice_p (grp_prop[k]),
      .slice_g (grp_gen[k])
    );
  end

  assign carry_out = grp_cin[NUM_SLICES];
endmodule

// File: rtl/cla16_adder_chk.sv
module cla16_adder_chk #(
  parameter int unsigned SLICE_W    = 4,
  parameter int unsigned NUM_SLICES = 4,
  localparam int unsigned WIDTH     = SLICE_W * NUM_SLICES
) (
  input logic [WIDTH-1:0]      op_a,
  input logic [WIDTH-1:0]      op_b,
  input logic                  carry_in,
  input logic [WIDTH-1:0]      sum,
  input logic                  carry_out,
  input logic [NUM_SLICES-1:0] grp_prop,
  input logic [NUM_SLICES-1:0] grp_gen,
  input logic [NUM_SLICES:0]   grp_cin
);
  logic [WIDTH:0] ref_total;
  assign ref_total = {1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in};

  always_comb begin
    assert_sum_R1: assert (sum == ref_total[WIDTH-1:0])
      else $error("R1 sum mismatch");
    assert_cout_R2: assert (carry_out == ref_total[WIDTH])
      else $error("R2 carry_out mismatch");
    assert_cin0_R5: assert (grp_cin[0] == carry_in)
      else $error("R5 slice 0 carry mismatch");
  end

  for (genvar k = 0; k < NUM_SLICES; k++) begin : g_chk
    logic [SLICE_W:0] slice_total;
    assign slice_total = {1'b0, op_a[k*SLICE_W +: SLICE_W]}
                       + {1'b0, op_b[k*SLICE_W +: SLICE_W]};
    always_comb begin
      assert_prop_R3: assert (grp_prop[k] ==
          ((op_a[k*SLICE_W +: SLICE_W] | op_b[k*SLICE_W +: SLICE_W]) == {SLICE_W{1'b1}}))
        else $error("R3 slice propagate mismatch");
      assert_gen_R4: assert (grp_gen[k] == slice_total[SLICE_W])
        else $error("R4 slice generate mismatch");
      assert_chain_R5: assert (grp_cin[k+1] == (grp_gen[k] | (grp_prop[k] & grp_cin[k])))
        else $error("R5 lookahead carry mismatch");
    end
  end
endmodule

bind cla16_adder cla16_adder_chk #(.SLICE_W(SLICE_W), .NUM_SLICES(NUM_SLICES)) u_chk (
  .op_a      (op_a),
  .op_b      (op_b),
  .carry_in  (carry_in),
  .sum       (sum),
  .carry_out (carry_out),
  .grp_prop  (grp_prop),
  .grp_gen   (grp_gen),
  .grp_cin   (grp_cin)
);

// File: tb/cla16_adder_tb.sv
module cla16_adder_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] op_a = '0;
  logic [15:0] op_b = '0;
  logic        carry_in = 1'b0;
  logic [15:0] sum;
  logic        carry_out;
  logic [3:0]  grp_prop;
  logic [3:0]  grp_gen;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  cla16_adder u_dut (
    .op_a      (op_a),
    .op_b      (op_b),
    .carry_in  (carry_in),
    .sum       (sum),
    .carry_out (carry_out),
    .grp_prop  (grp_prop),
    .grp_gen   (grp_gen)
  );

  // Behavioural model built on plain integer arithmetic.
  task automatic check_now(input string tag);
    int unsigned total;
    logic [3:0] exp_p;
    logic [3:0] exp_g;
    total = int'(op_a) + int'(op_b) + int'(carry_in);
    for (int k = 0; k < 4; k++) begin
      int unsigned na;
      int unsigned nb;
      na = (int'(op_a) >> (4*k)) % 16;
      nb = (int'(op_b) >> (4*k)) % 16;
      exp_g[k] = (na + nb) >= 16;
      exp_p[k] = 1'b1;
      for (int i = 0; i < 4; i++)
        if (((na >> i) % 2 == 0) && ((nb >> i) % 2 == 0)) exp_p[k] = 1'b0;
    end
    n_vec++;
    if (sum !== total[15:0]) begin
      n_fail++;
      $display("FAIL R1 %s: a=%h b=%h ci=%b sum=%h expected %h", tag, op_a, op_b, carry_in, sum, total[15:0]);
    end
    if (carry_out !== total[16]) begin
      n_fail++;
      $display("FAIL R2 %s: a=%h b=%h ci=%b carry_out=%b expected %b", tag, op_a, op_b, carry_in, carry_out, total[16]);
    end
    if (grp_prop !== exp_p) begin
      n_fail++;
      $display("FAIL R3 %s: a=%h b=%h grp_prop=%b expected %b", tag, op_a, op_b, grp_prop, exp_p);
    end
    if (grp_gen !== exp_g) begin
      n_fail++;
      $display("FAIL R4 %s: a=%h b=%h grp_gen=%b expected %b", tag, op_a, op_b, grp_gen, exp_g);
    end
  endtask

  task automatic apply(input logic [15:0] a, input logic [15:0] b, input logic ci, input string tag);
    @(posedge clk);
    #1;
    op_a = a;
    op_b = b;
    carry_in = ci;
    @(negedge clk);
    check_now(tag);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin : stim
    logic [15:0] corners [12];
    corners = '{16'h0000, 16'hFFFF, 16'h0001, 16'h8000, 16'h7FFF, 16'h000F,
                16'h00F0, 16'h0F00, 16'hF000, 16'h5555, 16'hAAAA, 16'h0FFF};
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_now("reset state R1 R2 R3 R4");
    rst = 1'b0;

    // R5: carry-in on a full propagate chain wraps to zero with carry-out.
    apply(16'hFFFF, 16'h0000, 1'b1, "R5 full chain");
    apply(16'h0000, 16'hFFFF, 1'b1, "R5 full chain mirrored");
    apply(16'hFFFF, 16'hFFFF, 1'b1, "R5 all generate");
    apply(16'h0FFF, 16'h0000, 1'b1, "R5 stops at slice 3");
    apply(16'h000F, 16'h0001, 1'b0, "R4 slice 0 generate");
    apply(16'hF0F0, 16'h0F0F, 1'b0, "R3 all slices propagate");

    // Exhaustive corner pairs, both carry-in values.
    foreach (corners[i])
      foreach (corners[j])
        for (int c = 0; c < 2; c++)
          apply(corners[i], corners[j], c[0], "corner R1 R2 R3 R4");

    // Random operands.
    for (int n = 0; n < 3000; n++)
      apply(16'($urandom), 16'($urandom), 1'($urandom), "random R1 R2 R3 R4");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule